// File: doc/BRIEF.md
# Page Attribute Output Drive Controller

This block owns a bus pin that tells system logic whether the page touched by the current bus cycle is writeback or writethrough. It decides, clock by clock, whether that pin is driven, and with which value. Driving begins in the clock where the address strobe is sampled for a qualifying cycle. It ends with the final burst-ready the cycle expects. That is four beats for a line (burst) transfer and one for a single transfer.

Many conditions keep the pin floating or stop a cycle that is already driving it: back-off (with a one-clock delay), hold acknowledge, reset, init, the stop-clock power state, and the low-power states that only let inquire-triggered writebacks through. Address hold blocks only new cycles; a cycle already under way runs to its last beat. The value sent out is captured at the strobe clock and held for the whole cycle. While the pin floats, the value output reads 0.

Top module: `pgattr_drive`

## Requirements
- R1: The enable goes high in the clock where a qualifying strobe is sampled and stays high through the clock carrying the last expected burst-ready: 4 ready beats when `req_burst_i`=1, 1 when it is 0. A burst-ready in the strobe clock itself does not count as a beat, and wait clocks without ready keep the enable high.
- R2: The driven value is `req_wt_i` as sampled at the strobe clock: 0 for a writeback page, 1 for a writethrough page. Later changes of `req_wt_i` do not alter it before the cycle ends.
- R3: In the normal power state (`pstate_i`=0), the cycle types memory read (0), memory write (1), writeback (2) and locked (3) enable the output.
- R4: Special cycles (type 4), interrupt acknowledge (type 5) and the unused codes 6 and 7 never enable the output.
- R5: In halt (1), shutdown (2) and stop-grant (3), only a writeback (type 2) with `req_snoop_i`=1 (caused by an inquire) enables the output.
- R6: In stop-clock (`pstate_i`=4), the output is never enabled.
- R7: When back-off is asserted during a driven cycle, the output stays driven in that clock, floats from the next clock on, and the cycle is abandoned. No new cycle starts in a clock where back-off is high or where it was high in the previous clock.
- R8: Hold acknowledge floats the output in the same clock it is asserted, abandons the cycle in progress, and blocks new cycles.
- R9: Reset or init floats the output in the same clock, clears the cycle in progress, and blocks new cycles.
- R10: While address hold is high, a strobe starts no cycle. A cycle that started earlier stays driven through its last beat.
- R11: Whenever the enable is low, `attr_o` is 0.
- R12: A strobe seen while a cycle is in progress is ignored: it changes neither the driven value nor the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Reset, active high, asynchronous clear and float |
| init_i | input | 1 | Init request, forces float |
| strobe_i | input | 1 | Address strobe of a new bus cycle |
| rdy_i | input | 1 | Burst-ready beat |
| ahold_i | input | 1 | Address hold from system logic |
| backoff_i | input | 1 | Back-off from system logic |
| hlda_i | input | 1 | Hold acknowledge |
| pstate_i | input | 3 | Power state: 0 normal, 1 halt, 2 shutdown, 3 stop-grant, 4 stop-clock |
| req_type_i | input | 3 | Cycle type: 0 mem read, 1 mem write, 2 writeback, 3 locked, 4 special, 5 int ack |
| req_wt_i | input | 1 | Page attribute: 1 writethrough, 0 writeback |
| req_burst_i | input | 1 | 1 for a four-beat line transfer, 0 for single |
| req_snoop_i | input | 1 | Writeback was caused by an inquire cycle |
| attr_o | output | 1 | Attribute value to the pin |
| attr_oe_o | output | 1 | Output enable of the pin |

## Verification
The bench sweeps every combination of power state, cycle type, inquire flag, attribute and transfer length, and counts beats through a wait clock. A design that counted the strobe-clock ready, or miscounted burst beats, would drop the enable early or late. A design that latched the attribute late would follow the deliberately flipped `req_wt_i`. Directed sequences target three timing edges: the one-clock lag after back-off (a design that floats at once, or never, is caught), the same-clock float on hold acknowledge, and a four-beat cycle finishing under address hold while a fresh strobe under that hold stays dark. A second strobe inside a running cycle checks that no restart or value swap occurs.

// File: rtl/pgattr_pkg.sv
package pgattr_pkg;
   localparam int TYPE_W   = 3;
   localparam int PSTATE_W = 3;

   typedef enum logic [TYPE_W-1:0] {
      CT_MEM_RD  = 3'd0,
      CT_MEM_WR  = 3'd1,
      CT_WRBACK  = 3'd2,
      CT_LOCKED  = 3'd3,
      CT_SPECIAL = 3'd4,
      CT_INTACK  = 3'd5
   } cyc_type_e;

   typedef enum logic [PSTATE_W-1:0] {
      PS_NORMAL   = 3'd0,
      PS_HALT     = 3'd1,
      PS_SHUTDOWN = 3'd2,
      PS_STOPGNT  = 3'd3,
      PS_STOPCLK  = 3'd4
   } pwr_state_e;
endpackage

// File: rtl/pgattr_qualify.sv
module pgattr_qualify
   import pgattr_pkg::*;
#(
   parameter bit LOWPWR_SNOOP_WB = 1'b1
) (
   input  logic [TYPE_W-1:0]   type_i,
   input  logic [PSTATE_W-1:0] pstate_i,
   input  logic                snoop_i,
   output logic                ok_o
);
   logic drv_type;
   logic low_pwr;
   logic lp_pass;

   assign drv_type = (type_i == CT_MEM_RD) || (type_i == CT_MEM_WR) ||
                     (type_i == CT_WRBACK) || (type_i == CT_LOCKED);
   assign low_pwr  = (pstate_i == PS_HALT) || (pstate_i == PS_SHUTDOWN) ||
                     (pstate_i == PS_STOPGNT);

   generate
      if (LOWPWR_SNOOP_WB) begin : g_lp_snoop
         assign lp_pass = low_pwr && (type_i == CT_WRBACK) && snoop_i;
      end else begin : g_lp_none
         assign lp_pass = 1'b0;
      end
   endgenerate

   assign ok_o = drv_type && ((pstate_i == PS_NORMAL) || lp_pass);
endmodule

// File: rtl/pgattr_boff.sv
module pgattr_boff #(
   parameter int FLOAT_DLY = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic backoff_i,
   output logic block_o,
   output logic float_o
);
   generate
      if (FLOAT_DLY != 0 && FLOAT_DLY != 1) begin : g_bad_dly
         $error("pgattr_boff: FLOAT_DLY must be 0 or 1");
      end
      if (FLOAT_DLY == 1) begin : g_dly
         logic boff_q;
         always_ff @(posedge clk or posedge rst) begin
            if (rst) boff_q <= 1'b0;
            else     boff_q <= backoff_i;
         end
         assign float_o = boff_q;
         assign block_o = backoff_i | boff_q;
      end else begin : g_now
         assign float_o = backoff_i;
         assign block_o = backoff_i;
      end
   endgenerate
endmodule

// File: rtl/pgattr_track.sv
module pgattr_track #(
   parameter int BURST_BEATS  = 4,
   parameter int SINGLE_BEATS = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   input  logic burst_i,
   input  logic wt_i,
   input  logic rdy_i,
   input  logic kill_i,
   output logic active_o,
   output logic wt_o
);
   localparam int CNT_W = $clog2(BURST_BEATS + 1);

   generate
      if (SINGLE_BEATS < 1 || BURST_BEATS < SINGLE_BEATS) begin : g_bad_beats
         $error("pgattr_track: need 1 <= SINGLE_BEATS <= BURST_BEATS");
      end
   endgenerate

   logic [CNT_W-1:0] left_q;
   logic             active_q;
   logic             wt_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         active_q <= 1'b0;
         left_q   <= '0;
         wt_q     <= 1'b0;
      end else if (kill_i) begin
         active_q <= 1'b0;
         left_q   <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         left_q   <= burst_i ? CNT_W'(BURST_BEATS) : CNT_W'(SINGLE_BEATS);
         wt_q     <= wt_i;
      end else if (active_q && rdy_i) begin
         left_q <= left_q - 1'b1;
         if (left_q == CNT_W'(1)) active_q <= 1'b0;
      end
   end

   assign active_o = active_q;
   assign wt_o     = wt_q;

   // R1
   beats_live_chk: assert property (@(posedge clk) disable iff (rst)
      active_q |-> (left_q != '0 && left_q <= CNT_W'(BURST_BEATS)));
   // R12
   no_restart_chk: assert property (@(posedge clk) disable iff (rst)
      (active_q && !rdy_i && !kill_i) |=> (active_q && $stable(left_q) && $stable(wt_q)));
endmodule

// File: rtl/pgattr_drive.sv
module pgattr_drive
   import pgattr_pkg::*;
#(
   parameter int BURST_BEATS     = 4,
   parameter int SINGLE_BEATS    = 1,
   parameter int BOFF_FLOAT_DLY  = 1,
   parameter bit LOWPWR_SNOOP_WB = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                init_i,
   input  logic                strobe_i,
   input  logic                rdy_i,
   input  logic                ahold_i,
   input  logic                backoff_i,
   input  logic                hlda_i,
   input  logic [PSTATE_W-1:0] pstate_i,
   input  logic [TYPE_W-1:0]   req_type_i,
   input  logic                req_wt_i,
   input  logic                req_burst_i,
   input  logic                req_snoop_i,
   output logic                attr_o,
   output logic                attr_oe_o
);
   logic type_ok;
   logic boff_block;
   logic boff_float;
   logic active;
   logic wt_held;
   logic stop_clk;
   logic hard_off;
   logic start;
   logic kill;

   pgattr_qualify #(.LOWPWR_SNOOP_WB(LOWPWR_SNOOP_WB)) u_qual (
      .type_i   (req_type_i),
      .pstate_i (pstate_i),
      .snoop_i  (req_snoop_i),
      .ok_o     (type_ok)
   );

   pgattr_boff #(.FLOAT_DLY(BOFF_FLOAT_DLY)) u_boff (
      .clk       (clk),
      .rst       (rst),
      .backoff_i (backoff_i),
      .block_o   (boff_block),
      .float_o   (boff_float)
   );

   assign stop_clk = (pstate_i == PS_STOPCLK);
   assign hard_off = rst | init_i | hlda_i | stop_clk;
   assign start    = strobe_i & ~active & type_ok & ~ahold_i & ~boff_block & ~hard_off;
   assign kill     = hard_off | backoff_i;

   pgattr_track #(.BURST_BEATS(BURST_BEATS), .SINGLE_BEATS(SINGLE_BEATS)) u_trk (
      .clk      (clk),
      .rst      (rst),
      .start_i  (start),
      .burst_i  (req_burst_i),
      .wt_i     (req_wt_i),
      .rdy_i    (rdy_i),
      .kill_i   (kill),
      .active_o (active),
      .wt_o     (wt_held)
   );

   assign attr_oe_o = (start | active) & ~hard_off & ~boff_float;
   assign attr_o    = attr_oe_o & (start ? req_wt_i : wt_held);

   // R8
   hold_float_chk: assert property (@(posedge clk) disable iff (rst)
      hlda_i |-> !attr_oe_o);
   // R9
   init_float_chk: assert property (@(posedge clk) disable iff (rst)
      init_i |-> !attr_oe_o);
   // R7
   boff_late_float_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(backoff_i) && !$past(rst)) |-> !attr_oe_o);
   // R6
   stopclk_dark_chk: assert property (@(posedge clk) disable iff (rst)
      (pstate_i == PS_STOPCLK) |-> !attr_oe_o);
   // R4
   special_dark_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe_i && !active && req_type_i >= CT_SPECIAL) |-> !attr_oe_o);
   // R10
   ahold_no_start_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe_i && ahold_i && !active) |-> !attr_oe_o);
   // R2
   value_steady_chk: assert property (@(posedge clk) disable iff (rst)
      (attr_oe_o && active && $past(attr_oe_o) && $past(active)) |-> $stable(attr_o));
endmodule

// File: tb/pgattr_drive_tb.sv
`timescale 1ns/1ps
module pgattr_drive_tb;
   logic clk = 1'b0;
   logic rst, init_i, strobe_i, rdy_i, ahold_i, backoff_i, hlda_i;
   logic [2:0] pstate_i, req_type_i;
   logic req_wt_i, req_burst_i, req_snoop_i;
   logic attr_o, attr_oe_o;
   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   pgattr_drive u_dut (
      .clk(clk), .rst(rst), .init_i(init_i), .strobe_i(strobe_i), .rdy_i(rdy_i),
      .ahold_i(ahold_i), .backoff_i(backoff_i), .hlda_i(hlda_i), .pstate_i(pstate_i),
      .req_type_i(req_type_i), .req_wt_i(req_wt_i), .req_burst_i(req_burst_i),
      .req_snoop_i(req_snoop_i), .attr_o(attr_o), .attr_oe_o(attr_oe_o)
   );

   task automatic chk(input string req, input logic [1:0] exp);
      checks++;
      if ({attr_oe_o, attr_o} !== exp) begin
         failures++;
         $display("FAIL %s: oe,attr actual=%b expected=%b at %0t", req, {attr_oe_o, attr_o}, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic strobe(input logic [2:0] ty, input logic wt, input logic bu);
      tick(); strobe_i = 1'b1; req_type_i = ty; req_wt_i = wt; req_burst_i = bu; #1;
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst = 1'b1; init_i = 0; strobe_i = 0; rdy_i = 0; ahold_i = 0; backoff_i = 0;
      hlda_i = 0; pstate_i = 0; req_type_i = 0; req_wt_i = 0; req_burst_i = 0; req_snoop_i = 0;
      tick(); #1 chk("R9 reset", 2'b00);
      tick(); rst = 1'b0; #1 chk("R11 idle", 2'b00);

      // Sweep: R1 R2 R3 R4 R5 R6
      for (int ps = 0; ps < 5; ps++)
         for (int ty = 0; ty < 8; ty++)
            for (int sn = 0; sn < 2; sn++)
               for (int wt = 0; wt < 2; wt++)
                  for (int bu = 0; bu < 2; bu++) begin
                     logic ex;
                     string tag;
                     ex = (ty <= 3) && (ps == 0 || (ps <= 3 && ty == 2 && sn == 1));
                     tag = (ps == 4) ? "R6" : (ty >= 4) ? "R4" : (ps != 0) ? "R5" : "R3";
                     tick(); pstate_i = 3'(ps); req_snoop_i = sn[0];
                     strobe_i = 1'b1; req_type_i = 3'(ty); req_wt_i = wt[0]; req_burst_i = bu[0];
                     #1 chk(tag, {ex, ex & wt[0]});
                     tick(); strobe_i = 1'b0; req_wt_i = ~wt[0]; #1 chk("R1 wait", {ex, ex & wt[0]});
                     for (int b = 0; b < (bu ? 4 : 1); b++) begin
                        tick(); rdy_i = 1'b1; #1 chk("R2 beat", {ex, ex & wt[0]});
                     end
                     tick(); rdy_i = 1'b0; #1 chk("R11 after", 2'b00);
                  end
      pstate_i = 0; req_snoop_i = 0;

      // R1: ready in the strobe clock is not a beat
      tick(); strobe_i = 1; req_type_i = 0; req_wt_i = 1; req_burst_i = 0; rdy_i = 1; #1 chk("R1 strobe rdy", 2'b11);
      tick(); strobe_i = 0; #1 chk("R1 single beat", 2'b11);
      tick(); rdy_i = 0; #1 chk("R1 single end", 2'b00);

      // R7 back-off
      strobe(3'd0, 1'b1, 1'b1); chk("R7 start", 2'b11);
      tick(); strobe_i = 0; rdy_i = 1; #1 chk("R7 beat", 2'b11);
      tick(); rdy_i = 0; backoff_i = 1; #1 chk("R7 first clock driven", 2'b11);
      tick(); #1 chk("R7 floated", 2'b00);
      tick(); backoff_i = 0; strobe_i = 1; #1 chk("R7 start blocked", 2'b00);
      tick(); strobe_i = 0; rdy_i = 1; #1 chk("R7 abandoned", 2'b00);
      tick(); rdy_i = 0;
      strobe(3'd1, 1'b0, 1'b0); chk("R7 recovered", 2'b10);
      tick(); strobe_i = 0; rdy_i = 1; #1 chk("R7 recovered beat", 2'b10);
      tick(); rdy_i = 0; #1 chk("R7 recovered end", 2'b00);

      // R8 hold acknowledge
      strobe(3'd3, 1'b1, 1'b1); chk("R8 start", 2'b11);
      tick(); strobe_i = 0; hlda_i = 1; #1 chk("R8 same clock", 2'b00);
      tick(); strobe_i = 1; #1 chk("R8 start blocked", 2'b00);
      tick(); strobe_i = 0; hlda_i = 0; rdy_i = 1; #1 chk("R8 abandoned", 2'b00);
      tick(); rdy_i = 0;

      // R9 init and reset
      strobe(3'd0, 1'b1, 1'b1); chk("R9 start", 2'b11);
      tick(); strobe_i = 0; init_i = 1; #1 chk("R9 init float", 2'b00);
      tick(); init_i = 0; rdy_i = 1; #1 chk("R9 init cleared", 2'b00);
      tick(); rdy_i = 0;
      strobe(3'd0, 1'b1, 1'b1); chk("R9 start2", 2'b11);
      tick(); strobe_i = 0; rst = 1; #1 chk("R9 reset float", 2'b00);
      tick(); rst = 0; rdy_i = 1; #1 chk("R9 reset cleared", 2'b00);
      tick(); rdy_i = 0;

      // R10 address hold
      strobe(3'd2, 1'b1, 1'b1); chk("R10 start", 2'b11);
      for (int b = 0; b < 4; b++) begin
         tick(); strobe_i = 0; ahold_i = 1; rdy_i = 1; #1 chk("R10 finish under hold", 2'b11);
      end
      tick(); rdy_i = 0; #1 chk("R10 end", 2'b00);
      tick(); strobe_i = 1; #1 chk("R10 no new start", 2'b00);
      tick(); strobe_i = 0; ahold_i = 0; rdy_i = 1; #1 chk("R10 nothing started", 2'b00);
      tick(); rdy_i = 0;

      // R12 strobe inside running cycle
      strobe(3'd0, 1'b0, 1'b1); chk("R12 start", 2'b10);
      tick(); req_wt_i = 1; req_type_i = 3'd4; req_burst_i = 0; #1 chk("R12 second strobe", 2'b10);
      tick(); strobe_i = 0;
      for (int b = 0; b < 4; b++) begin
         tick(); rdy_i = 1; #1 chk("R12 beats kept", 2'b10);
      end
      tick(); rdy_i = 0; #1 chk("R12 end", 2'b00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule